// File: doc/BRIEF.md
# UART FIFO Level, Interrupt and Flow Controller

This block holds the transmit and receive queues of one UART channel and turns their fill levels into interrupt requests and a receive-side flow-control output. The host side pushes bytes into the transmit queue and pops bytes from the receive queue. The line side pops the transmit queue and pushes the receive queue. Both queues are 32 entries deep and each has its own occupancy counter.

A byte-wide configuration write sets up the block. The write carries a queue enable, two self-clearing flush commands, a DMA-mode flag and two trigger codes. The DMA flag is passed straight to the ready-pin logic outside this block. An enhanced-features input selects the trigger levels. When it is low, both trigger levels are one character. When it is high, the levels come from per-code tables. The enhanced input also guards the transmit trigger field against writes.

The receive trigger code also selects a pair of thresholds for the request-to-send output. The output drops when the receive queue reaches a release threshold. It comes back only when the queue has drained to a lower restore threshold. This hysteresis stops the output from toggling on every character.

Top module: `uart_fifo_flow`

## Requirements
- R1: After synchronous reset, both counts are 0, `fifo_en`, `dma_mode`, `tx_ovf`, `rx_ovf` and `rx_irq` are 0, `cfg_rdata` is 0x00, `rts_ok` is 1 and `tx_irq` is 1 because the transmit queue is empty.
- R2: Each queue holds 32 bytes and returns them in first-in first-out order. An accepted push raises the count by one and an accepted pop lowers it by one. A pop loads the oldest byte into the read-data output at that clock edge.
- R3: A push while the count is 32 is dropped and the count stays at 32. The matching overflow output is 1 for exactly the one cycle after that edge.
- R4: A pop while the count is 0 leaves the count at 0 and keeps the read-data output at the last byte popped.
- R5: Configuration bit 0 is the queue enable, bit 3 is DMA mode and bits [7:6] are the receive trigger code. `cfg_rdata` returns {rx code, tx code, dma, 0, 0, enable}, so the flush bits always read back as 0.
- R6: Bit 1 flushes the receive queue and bit 2 flushes the transmit queue, only when bit 0 is 1 in the same write. The count is 0 right after that edge. The queue's read-data output and the other queue are left unchanged.
- R7: Bits [5:4], the transmit trigger code, are written only while `enh_en` is 1. Otherwise the stored code keeps its value.
- R8: With `enh_en` at 0, both trigger levels are 1. With `enh_en` at 1, transmit codes 0/1/2/3 give 16/8/24/30 and receive codes 0/1/2/3 give 8/16/24/28.
- R9: `rx_irq` is 1 exactly while the receive count is at or above the receive trigger level.
- R10: `tx_irq` is 1 when the transmit count is 0. It is also 1 when the count is below the transmit level and has been above that level since the queue was last empty.
- R11: `rts_ok` goes to 0 one cycle after the receive count reaches the release threshold, which is 16/24/28/28 for receive codes 0/1/2/3. It returns to 1 one cycle after the count is at or below the restore threshold, which is 0/8/16/24. Between the two thresholds it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| enh_en | input | 1 | Enhanced features enable |
| cfg_rdata | output | 8 | Configuration readback |
| fifo_en | output | 1 | Stored queue enable |
| dma_mode | output | 1 | Stored DMA mode flag |
| tx_push | input | 1 | Host writes a byte to the transmit queue |
| tx_wdata | input | 8 | Transmit push data |
| tx_pop | input | 1 | Line side takes a byte from the transmit queue |
| tx_rdata | output | 8 | Last byte taken from the transmit queue |
| tx_count | output | 6 | Transmit queue occupancy |
| tx_ovf | output | 1 | Transmit push dropped on full |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_push | input | 1 | Line side stores a received byte |
| rx_wdata | input | 8 | Receive push data |
| rx_pop | input | 1 | Host reads a byte from the receive queue |
| rx_rdata | output | 8 | Last byte read from the receive queue |
| rx_count | output | 6 | Receive queue occupancy |
| rx_ovf | output | 1 | Receive push dropped on full |
| rx_irq | output | 1 | Receive level interrupt |
| rts_ok | output | 1 | Flow-control output, 1 lets the far end send |

## Verification
The hardest state to reach is the hysteresis band of the flow-control output. There the receive count lies between the restore and release thresholds, and the correct output depends on the direction from which the count arrived. The bench fills the receive queue past the release threshold and then drains it one byte at a time. It checks that the output stays low just above the restore threshold and rises only at it. The transmit interrupt has a similar history: it depends on whether the last refill crossed the trigger level. The bench therefore drains from a level above the trigger and also from one below it. To show that the guarded transmit trigger field was left alone, the bench reads it back through the configuration port.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    localparam int DEPTH = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       dma;
        logic       en;
    } cfg_t;

    typedef struct packed {
        logic tx_flush;
        logic rx_flush;
    } flush_t;

    function automatic cnt_t tx_level_f(input logic [1:0] code, input logic enh);
        cnt_t lv;
        if (!enh) begin
            lv = cnt_t'(1);
        end else begin
            case (code)
                2'd0:    lv = cnt_t'(16);
                2'd1:    lv = cnt_t'(8);
                2'd2:    lv = cnt_t'(24);
                default: lv = cnt_t'(30);
            endcase
        end
        return lv;
    endfunction

    function automatic cnt_t rx_level_f(input logic [1:0] code, input logic enh);
        cnt_t lv;
        if (!enh) begin
            lv = cnt_t'(1);
        end else begin
            case (code)
                2'd0:    lv = cnt_t'(8);
                2'd1:    lv = cnt_t'(16);
                2'd2:    lv = cnt_t'(24);
                default: lv = cnt_t'(28);
            endcase
        end
        return lv;
    endfunction

    function automatic cnt_t rts_release_f(input logic [1:0] code);
        cnt_t lv;
        case (code)
            2'd0:    lv = cnt_t'(16);
            2'd1:    lv = cnt_t'(24);
            default: lv = cnt_t'(28);
        endcase
        return lv;
    endfunction

    function automatic cnt_t rts_restore_f(input logic [1:0] code);
        return cnt_t'({code, 3'b000});
    endfunction

endpackage

// File: rtl/uaf_fifo.sv
module uaf_fifo
    import uaf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output cnt_t         count,
    output logic         ovf
);

    localparam int   AW   = $clog2(DEPTH);
    localparam cnt_t FULL = cnt_t'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == FULL);
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            rdata <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && full && !flush;
            if (flush) begin
                wp    <= '0;
                rp    <= '0;
                count <= '0;
            end else begin
                if (do_push) begin
                    wp <= wp + AW'(1);
                end
                if (do_pop) begin
                    rp    <= rp + AW'(1);
                    rdata <= mem[rp];
                end
                case ({do_push, do_pop})
                    2'b10:   count <= count + cnt_t'(1);
                    2'b01:   count <= count - cnt_t'(1);
                    default: count <= count;
                endcase
            end
        end
    end

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && count == FULL) |=> (count == FULL && ovf));

    assert_empty_pop_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush && count == '0) |=> (count == '0 && $stable(rdata)));

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && $stable(rdata)));

endmodule

// File: rtl/uaf_ctrl.sv
module uaf_ctrl
    import uaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       enh,
    output cfg_t       cfg,
    output flush_t     fl,
    output logic [7:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg.en      <= wdata[0];
            cfg.dma     <= wdata[3];
            cfg.rx_code <= wdata[7:6];
            if (enh) begin
                cfg.tx_code <= wdata[5:4];
            end
        end
    end

    // Flush acts on the same edge as the write, so the bits never persist.
    assign fl.rx_flush = we && wdata[0] && wdata[1];
    assign fl.tx_flush = we && wdata[0] && wdata[2];

    assign rdata = {cfg.rx_code, cfg.tx_code, cfg.dma, 2'b00, cfg.en};

    assert_tx_field_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (we && !enh) |=> $stable(cfg.tx_code));

    assert_flush_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        (fl.tx_flush || fl.rx_flush) |=> cfg.en);

endmodule

// File: rtl/uaf_txlvl.sv
module uaf_txlvl
    import uaf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t count,
    input  cnt_t level,
    output logic irq
);

    logic hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= 1'b0;
        end else if (count > level) begin
            hi <= 1'b1;
        end else if (count == '0) begin
            hi <= 1'b0;
        end
    end

    assign irq = (count == '0) || (hi && (count < level));

    assert_empty_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> irq);

    assert_quiet_after_refill_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(count) > level && count >= level) |-> !irq);

endmodule

// File: rtl/uaf_rxlvl.sv
module uaf_rxlvl
    import uaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cnt_t       count,
    input  logic [1:0] code,
    input  cnt_t       level,
    output logic       irq,
    output logic       rts
);

    cnt_t rel, rest;

    assign rel  = rts_release_f(code);
    assign rest = rts_restore_f(code);
    assign irq  = (count >= level);

    always_ff @(posedge clk) begin
        if (rst) begin
            rts <= 1'b1;
        end else if (count >= rel) begin
            rts <= 1'b0;
        end else if (count <= rest) begin
            rts <= 1'b1;
        end
    end

    assert_rts_release_R11: assert property (@(posedge clk) disable iff (rst)
        (count >= rel) |=> !rts);

    assert_rts_restore_R11: assert property (@(posedge clk) disable iff (rst)
        (count <= rest) |=> rts);

    assert_rts_band_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (count > rest && count < rel) |=> $stable(rts));

endmodule

// File: rtl/uart_fifo_flow.sv
module uart_fifo_flow
    import uaf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [7:0]   cfg_wdata,
    input  logic         enh_en,
    output logic [7:0]   cfg_rdata,
    output logic         fifo_en,
    output logic         dma_mode,
    input  logic         tx_push,
    input  logic [W-1:0] tx_wdata,
    input  logic         tx_pop,
    output logic [W-1:0] tx_rdata,
    output logic [CW-1:0] tx_count,
    output logic         tx_ovf,
    output logic         tx_irq,
    input  logic         rx_push,
    input  logic [W-1:0] rx_wdata,
    input  logic         rx_pop,
    output logic [W-1:0] rx_rdata,
    output logic [CW-1:0] rx_count,
    output logic         rx_ovf,
    output logic         rx_irq,
    output logic         rts_ok
);

    cfg_t   cfg;
    flush_t fl;
    cnt_t   tx_lv, rx_lv;

    uaf_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .wdata(cfg_wdata),
        .enh  (enh_en),
        .cfg  (cfg),
        .fl   (fl),
        .rdata(cfg_rdata)
    );

    assign fifo_en  = cfg.en;
    assign dma_mode = cfg.dma;
    assign tx_lv    = tx_level_f(cfg.tx_code, enh_en);
    assign rx_lv    = rx_level_f(cfg.rx_code, enh_en);

    uaf_fifo #(.W(W)) u_txq (
        .clk  (clk),
        .rst  (rst),
        .flush(fl.tx_flush),
        .push (tx_push),
        .wdata(tx_wdata),
        .pop  (tx_pop),
        .rdata(tx_rdata),
        .count(tx_count),
        .ovf  (tx_ovf)
    );

    uaf_fifo #(.W(W)) u_rxq (
        .clk  (clk),
        .rst  (rst),
        .flush(fl.rx_flush),
        .push (rx_push),
        .wdata(rx_wdata),
        .pop  (rx_pop),
        .rdata(rx_rdata),
        .count(rx_count),
        .ovf  (rx_ovf)
    );

    uaf_txlvl u_txlvl (
        .clk  (clk),
        .rst  (rst),
        .count(tx_count),
        .level(tx_lv),
        .irq  (tx_irq)
    );

    uaf_rxlvl u_rxlvl (
        .clk  (clk),
        .rst  (rst),
        .count(rx_count),
        .code (cfg.rx_code),
        .level(rx_lv),
        .irq  (rx_irq),
        .rts  (rts_ok)
    );

endmodule

// File: tb/test_uart_fifo_flow.sv
module test_uart_fifo_flow;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       enh_en = 1'b0;
    logic [7:0] cfg_rdata;
    logic       fifo_en, dma_mode;
    logic       tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, tx_rdata;
    logic [5:0] tx_count;
    logic       tx_ovf, tx_irq;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_wdata = '0, rx_rdata;
    logic [5:0] rx_count;
    logic       rx_ovf, rx_irq, rts_ok;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_fifo_flow i_uart_fifo_flow (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .enh_en(enh_en), .cfg_rdata(cfg_rdata), .fifo_en(fifo_en),
        .dma_mode(dma_mode), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_count(tx_count),
        .tx_ovf(tx_ovf), .tx_irq(tx_irq), .rx_push(rx_push),
        .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_count(rx_count), .rx_ovf(rx_ovf), .rx_irq(rx_irq),
        .rts_ok(rts_ok)
    );

    // {rx code[9:8], rx count[7:2], expected rx_irq[1], expected rts_ok[0]}
    localparam logic [9:0] VEC [0:8] = '{
        {2'd0, 6'd7,  1'b0, 1'b1},
        {2'd0, 6'd8,  1'b1, 1'b1},
        {2'd0, 6'd16, 1'b1, 1'b0},
        {2'd1, 6'd15, 1'b0, 1'b1},
        {2'd1, 6'd24, 1'b1, 1'b0},
        {2'd2, 6'd27, 1'b1, 1'b1},
        {2'd2, 6'd28, 1'b1, 1'b0},
        {2'd3, 6'd27, 1'b0, 1'b1},
        {2'd3, 6'd28, 1'b1, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic [7:0] v, input logic e);
        enh_en    = e;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic push_tx(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            tx_push  = 1'b1;
            tx_wdata = 8'(base + i);
            tick();
        end
        tx_push = 1'b0;
    endtask

    task automatic pop_tx(input int n);
        for (int i = 0; i < n; i++) begin
            tx_pop = 1'b1;
            tick();
        end
        tx_pop = 1'b0;
    endtask

    task automatic push_rx(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            rx_push  = 1'b1;
            rx_wdata = 8'(base + i);
            tick();
        end
        rx_push = 1'b0;
    endtask

    task automatic pop_rx(input int n);
        for (int i = 0; i < n; i++) begin
            rx_pop = 1'b1;
            tick();
        end
        rx_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 tx_count", tx_count, 0);
        check("R1 rx_count", rx_count, 0);
        check("R1 cfg_rdata", cfg_rdata, 0);
        check("R1 fifo_en", fifo_en, 0);
        check("R1 dma_mode", dma_mode, 0);
        check("R1 rts_ok", rts_ok, 1);
        check("R1 tx_irq", tx_irq, 1);
        check("R1 rx_irq", rx_irq, 0);
        check("R1 ovf", {tx_ovf, rx_ovf}, 0);

        // R8 R9 R11 table walk: flush rx, set code, fill, check
        for (int v = 0; v < 9; v++) begin
            wr_cfg({VEC[v][9:8], 6'b000011}, 1'b1);
            push_rx(int'(VEC[v][7:2]), 0);
            tick();
            check("R2 rx_count", rx_count, int'(VEC[v][7:2]));
            check("R9 R8 rx_irq", rx_irq, VEC[v][1]);
            check("R11 rts_ok", rts_ok, VEC[v][0]);
        end

        // R11 hysteresis on drain, code 1 (release 24, restore 8)
        wr_cfg(8'h43, 1'b1);
        push_rx(24, 0);
        tick();
        check("R11 released", rts_ok, 0);
        pop_rx(15);
        tick();
        check("R11 band hold", rts_ok, 0);
        check("R9 below level", rx_irq, 0);
        pop_rx(1);
        tick();
        check("R11 restored", rts_ok, 1);

        // R2 order, R4 empty pop
        wr_cfg(8'h03, 1'b0);
        push_rx(3, 8'hA1);
        check("R9 legacy level one", rx_irq, 1);
        pop_rx(1);
        check("R2 first out", rx_rdata, 8'hA1);
        pop_rx(2);
        check("R2 third out", rx_rdata, 8'hA3);
        check("R2 drained", rx_count, 0);
        pop_rx(1);
        check("R4 rdata held", rx_rdata, 8'hA3);
        check("R4 count zero", rx_count, 0);

        // R3 overflow
        wr_cfg(8'h05, 1'b0);
        push_tx(32, 8'h40);
        check("R3 full count", tx_count, 32);
        check("R3 no ovf yet", tx_ovf, 0);
        push_tx(1, 8'hEE);
        check("R3 ovf pulse", tx_ovf, 1);
        check("R3 count held", tx_count, 32);
        tick();
        check("R3 ovf one cycle", tx_ovf, 0);
        pop_tx(1);
        check("R2 tx first out", tx_rdata, 8'h40);

        // R6 flush gating and side effects
        push_rx(3, 8'h10);
        wr_cfg(8'h04, 1'b0);
        check("R6 no flush without enable", tx_count, 31);
        wr_cfg(8'h05, 1'b0);
        check("R6 tx flushed", tx_count, 0);
        check("R6 tx_rdata kept", tx_rdata, 8'h40);
        check("R6 rx untouched", rx_count, 3);
        check("R5 flush bits read zero", cfg_rdata, 8'h01);

        // R5 decode and readback
        wr_cfg(8'hC9, 1'b1);
        check("R5 readback", cfg_rdata, 8'hC9);
        check("R5 dma_mode", dma_mode, 1);
        check("R5 fifo_en", fifo_en, 1);
        wr_cfg(8'h0E, 1'b1);
        check("R6 rx not flushed", rx_count, 3);
        check("R5 readback disabled", cfg_rdata, 8'h08);
        check("R5 fifo_en off", fifo_en, 0);

        // R7 guarded transmit trigger field
        wr_cfg(8'h21, 1'b1);
        wr_cfg(8'h11, 1'b0);
        check("R7 tx code kept", cfg_rdata, 8'h21);
        wr_cfg(8'h11, 1'b1);
        check("R7 tx code written", cfg_rdata, 8'h11);

        // R10 R8 transmit interrupt, code 1 level 8
        wr_cfg(8'h15, 1'b1);
        check("R10 empty irq", tx_irq, 1);
        push_tx(5, 0);
        check("R10 low refill quiet", tx_irq, 0);
        pop_tx(5);
        check("R10 empty after low refill", tx_irq, 1);
        push_tx(10, 0);
        check("R10 above level quiet", tx_irq, 0);
        pop_tx(2);
        check("R10 at level quiet", tx_irq, 0);
        pop_tx(1);
        check("R10 below level fires", tx_irq, 1);

        // R8 transmit code 0 gives level 16
        wr_cfg(8'h05, 1'b1);
        push_tx(20, 0);
        pop_tx(4);
        check("R8 tx level 16 at 16", tx_irq, 0);
        pop_tx(1);
        check("R8 tx level 16 at 15", tx_irq, 1);

        // R7 R10 field kept with enh off, observed after enh on: code 2 (24)
        wr_cfg(8'h25, 1'b1);
        wr_cfg(8'h15, 1'b0);
        enh_en = 1'b1;
        push_tx(20, 0);
        pop_tx(13);
        check("R7 R10 level 24 kept", tx_irq, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule